// File: doc/BRIEF.md
# Card Clock Generator with Staged Update

This block produces the clock driven to an SD/MMC card from the controller's source clock. Software writes a divider value, a run enable and a low-power gating enable into a clock control register. Those values are only held there. The running card clock picks them up when an update-only command word is written. That command sends nothing on the command line. The start flag of the command word reads back as 1 until the new settings are live, so software can poll it.

The card clock can run straight from the source clock, or from a divided clock with a 50 % duty cycle. New settings are switched in only at a point where the card clock is, or is about to go, low. As a result, no high or low phase is ever shortened. With low-power gating on, the clock stops low while the command and data paths report idle.

The same register port also holds the global control register. Three of its request bits (controller, FIFO and DMA reset) clear themselves once their reset has run for its fixed length. A poller can therefore wait on them. Three mode bits (interrupt enable, DMA enable, double-data-rate) are plain read/write fields, and each is brought out as a pin.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, every register reads 0, all reset-busy outputs and mode outputs are 0, and the card clock stays low.
- R2: A write to the clock register (address 1: divider in bits 7:0, enable in bit 16, low-power in bit 17) reads back at once. It does not change the running card clock.
- R3: A write to the command address (address 2) with bit 31 (start) and bit 21 (update-only) both set makes bit 31 of that address read 1. The bit clears to 0 once the staged clock settings are live. A command word without bit 21 is ignored: it reads 0 and leaves the clock unchanged.
- R4: With divider 0, the card clock rises once per source clock cycle. With divider D > 0, it has a period of 2·D source cycles.
- R5: With the enable bit 0 in the live settings, the card clock stays low.
- R6: With low-power gating live, the card clock stops low while the busIdle input is high, and runs while busIdle is low.
- R7: When the divider is changed while the clock runs, no high or low phase of the divided clock is shorter than the smaller of the old and new divider.
- R8: Writing 1 to global control bit 0, 1 or 2 (address 0) sets that bit and the matching busy output for exactly SOFT_LEN, FIFO_LEN or DMA_LEN cycles. The bit then reads 0.
- R9: Global control bits 4, 10 and 5 read back as written and drive irqEnable, ddrMode and dmaEnable. A second write during a reset does not restart or shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; every register of the block runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 global control, 1 clock control, 2 command |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register selected by addr (combinational) |
| busIdle | input | 1 | High while the command and data paths are idle |
| cardClk | output | 1 | Clock to the card |
| softRstBusy | output | 1 | Controller reset in progress |
| fifoRstBusy | output | 1 | FIFO reset in progress |
| dmaRstBusy | output | 1 | DMA reset in progress |
| irqEnable | output | 1 | Interrupt enable mode bit |
| dmaEnable | output | 1 | DMA enable mode bit |
| ddrMode | output | 1 | Double-data-rate mode bit |

## Verification
A live-settings register that loads at the wrong time shows up within one card-clock period. The bench sees it as a wrong edge count over a fixed window, or as a phase shorter than the divider when the change happens in mid-run. A pending flag that never clears shows as a start bit still set after a short poll. One that clears too early shows as start reading 0 while the old frequency still runs. A reset counter that is off by one shows as the busy pin lasting one cycle too long or too short. The bench measures that length exactly, from the cycle after the write.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int DIV_W    = 8;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_GCTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLK  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd2;

  localparam int BIT_SOFT = 0;
  localparam int BIT_FIFO = 1;
  localparam int BIT_DMA  = 2;
  localparam int BIT_IRQ  = 4;
  localparam int BIT_DMAE = 5;
  localparam int BIT_DDR  = 10;

  localparam int BIT_EN   = 16;
  localparam int BIT_LP   = 17;

  localparam int BIT_START = 31;
  localparam int BIT_UPD   = 21;

  localparam int NUM_RST  = 3;

  typedef struct packed {
    logic             load;
    logic [DIV_W-1:0] div;
    logic             en;
    logic             lp;
  } clkStrobe_t;
endpackage

// File: rtl/ccg_selfclear.sv
module ccg_selfclear #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic req,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      if (req) begin
        busy   <= 1'b1;
        remain <= CW'(LEN - 1);
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/ccg_ctrl.sv
module ccg_ctrl
  import ccg_pkg::*;
#(
  parameter int SOFT_LEN = 6,
  parameter int FIFO_LEN = 4,
  parameter int DMA_LEN  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              safeSlot,
  output clkStrobe_t        strobe,
  output logic              pending,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_RST-1:0] rstBusy,
  output logic              irqEn,
  output logic              dmaEn,
  output logic              ddrEn
);
  logic [DIV_W-1:0] stDiv;
  logic             stEn;
  logic             stLp;
  logic             applyNow;

  wire wrGctl = wrEn && (addr == ADDR_GCTL);
  wire wrClk  = wrEn && (addr == ADDR_CLK);
  wire wrCmd  = wrEn && (addr == ADDR_CMD) && wrData[BIT_START] && wrData[BIT_UPD];

  assign applyNow = pending && safeSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stDiv   <= '0;
      stEn    <= 1'b0;
      stLp    <= 1'b0;
      pending <= 1'b0;
      irqEn   <= 1'b0;
      dmaEn   <= 1'b0;
      ddrEn   <= 1'b0;
    end else begin
      if (wrClk) begin
        stDiv <= wrData[DIV_W-1:0];
        stEn  <= wrData[BIT_EN];
        stLp  <= wrData[BIT_LP];
      end
      if (wrCmd)         pending <= 1'b1;
      else if (applyNow) pending <= 1'b0;
      if (wrGctl) begin
        irqEn <= wrData[BIT_IRQ];
        dmaEn <= wrData[BIT_DMAE];
        ddrEn <= wrData[BIT_DDR];
      end
    end
  end

  always_comb begin
    strobe.load = applyNow;
    strobe.div  = stDiv;
    strobe.en   = stEn;
    strobe.lp   = stLp;
  end

  for (genvar i = 0; i < NUM_RST; i++) begin : g_rst
    localparam int L = (i == BIT_SOFT) ? SOFT_LEN : (i == BIT_FIFO) ? FIFO_LEN : DMA_LEN;
    ccg_selfclear #(.LEN(L)) u_sc (
      .clk (clk),
      .rstN(rstN),
      .req (wrGctl && wrData[i]),
      .busy(rstBusy[i])
    );
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_GCTL: begin
        rdData[NUM_RST-1:0] = rstBusy;
        rdData[BIT_IRQ]     = irqEn;
        rdData[BIT_DMAE]    = dmaEn;
        rdData[BIT_DDR]     = ddrEn;
      end
      ADDR_CLK: begin
        rdData[DIV_W-1:0] = stDiv;
        rdData[BIT_EN]    = stEn;
        rdData[BIT_LP]    = stLp;
      end
      ADDR_CMD: rdData[BIT_START] = pending;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/ccg_datapath.sv
module ccg_datapath
  import ccg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  clkStrobe_t strobe,
  input  logic       busIdle,
  output logic       safeSlot,
  output logic       cardClk,
  output logic       divClk,
  output logic       terminal,
  output logic       run
);
  logic [DIV_W-1:0] actDiv;
  logic             actEn;
  logic             actLp;
  logic [DIV_W-1:0] halfCnt;
  logic             selN;
  logic             gateN;
  logic             bypass;

  assign bypass   = (actDiv == '0);
  assign run      = actEn && !(actLp && busIdle);
  assign terminal = !bypass && (halfCnt == actDiv - 1'b1);
  assign safeSlot = bypass || (terminal && (divClk || !run));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actDiv  <= '0;
      actEn   <= 1'b0;
      actLp   <= 1'b0;
      halfCnt <= '0;
      divClk  <= 1'b0;
    end else if (strobe.load) begin
      actDiv  <= strobe.div;
      actEn   <= strobe.en;
      actLp   <= strobe.lp;
      halfCnt <= '0;
      divClk  <= 1'b0;
    end else if (bypass) begin
      halfCnt <= '0;
      divClk  <= 1'b0;
    end else if (terminal) begin
      halfCnt <= '0;
      divClk  <= run ? ~divClk : 1'b0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      selN  <= 1'b0;
      gateN <= 1'b0;
    end else begin
      selN  <= bypass;
      gateN <= bypass && run;
    end
  end

  assign cardClk = selN ? (clk & gateN) : divClk;
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import ccg_pkg::*;
#(
  parameter int SOFT_LEN = 6,
  parameter int FIFO_LEN = 4,
  parameter int DMA_LEN  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              busIdle,
  output logic              cardClk,
  output logic              softRstBusy,
  output logic              fifoRstBusy,
  output logic              dmaRstBusy,
  output logic              irqEnable,
  output logic              dmaEnable,
  output logic              ddrMode
);
  clkStrobe_t         strobe;
  logic               safeSlot;
  logic               pending;
  logic [NUM_RST-1:0] rstBusy;
  logic               divClk;
  logic               terminal;
  logic               run;

  ccg_ctrl #(.SOFT_LEN(SOFT_LEN), .FIFO_LEN(FIFO_LEN), .DMA_LEN(DMA_LEN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .safeSlot(safeSlot),
    .strobe  (strobe),
    .pending (pending),
    .rdData  (rdData),
    .rstBusy (rstBusy),
    .irqEn   (irqEnable),
    .dmaEn   (dmaEnable),
    .ddrEn   (ddrMode)
  );

  ccg_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busIdle (busIdle),
    .safeSlot(safeSlot),
    .cardClk (cardClk),
    .divClk  (divClk),
    .terminal(terminal),
    .run     (run)
  );

  assign softRstBusy = rstBusy[BIT_SOFT];
  assign fifoRstBusy = rstBusy[BIT_FIFO];
  assign dmaRstBusy  = rstBusy[BIT_DMA];
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker
  import ccg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wrData,
  input logic              irqEnable,
  input logic              softRstBusy,
  input logic              pending,
  input logic              applyLoad,
  input logic              divClk,
  input logic              terminal,
  input logic              run
);
  AST_DIV_EDGE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divClk) |-> ($past(terminal) || $past(applyLoad))) else $error("divided clock moved off a boundary"); // R7

  AST_APPLY_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    applyLoad |=> !divClk) else $error("settings applied with clock left high"); // R7

  AST_START_CLEARS_ON_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> $past(applyLoad)) else $error("start flag cleared without apply"); // R3

  AST_STOPPED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !divClk && !applyLoad) |=> !divClk) else $error("stopped clock rose"); // R5

  AST_RESET_BIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRstBusy) |-> $past(wrEn && (addr == ADDR_GCTL) && wrData[BIT_SOFT])) else $error("reset busy without request"); // R8

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == ADDR_GCTL)) |=> $stable(irqEnable)) else $error("mode bit changed without write"); // R9
endmodule

bind card_clk_gen ccg_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .irqEnable  (irqEnable),
  .softRstBusy(softRstBusy),
  .pending    (pending),
  .applyLoad  (strobe.load),
  .divClk     (divClk),
  .terminal   (terminal),
  .run        (run)
);

// File: tb/sim_card_clk_gen.sv
`timescale 1ns/1ps
module sim_card_clk_gen;
  localparam int SOFT_LEN = 6;
  localparam int FIFO_LEN = 4;
  localparam int DMA_LEN  = 10;
  localparam int WIN      = 120;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        busIdle = 1'b0;
  logic        cardClk;
  logic        softRstBusy, fifoRstBusy, dmaRstBusy;
  logic        irqEnable, dmaEnable, ddrMode;

  always #4 clk = ~clk;

  card_clk_gen #(.SOFT_LEN(SOFT_LEN), .FIFO_LEN(FIFO_LEN), .DMA_LEN(DMA_LEN)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .busIdle(busIdle), .cardClk(cardClk), .softRstBusy(softRstBusy), .fifoRstBusy(fifoRstBusy),
    .dmaRstBusy(dmaRstBusy), .irqEnable(irqEnable), .dmaEnable(dmaEnable), .ddrMode(ddrMode)
  );

  typedef struct { int v; string tag; } item_t;
  item_t expQ[$];
  item_t actQ[$];
  int tests = 0;
  int fails = 0;
  int edges = 0;
  bit done = 0;

  always @(posedge cardClk) edges++;

  // monitor: pops expected/actual pairs and compares them
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        item_t e, a;
        e = expQ.pop_front();
        a = actQ.pop_front();
        tests++;
        if (a.v != e.v) begin
          fails++;
          $display("FAIL %s: actual %0d expected %0d", e.tag, a.v, e.v);
        end
      end
    end
  end

  task automatic expect_val(input string tag, input int act, input int exp);
    item_t e, a;
    e.v = exp; e.tag = tag; a.v = act; a.tag = tag;
    expQ.push_back(e);
    actQ.push_back(a);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic measure(input int w, output int n);
    edges = 0;
    repeat (w) @(posedge clk);
    @(negedge clk);
    n = edges;
  endtask

  task automatic update(input string tag);
    logic [31:0] d;
    int k;
    wr(2'd2, 32'h8020_2000);
    rd(2'd2, d);
    expect_val({tag, " start reads 1"}, int'(d[31]), 1);
    k = 0;
    do begin
      @(negedge clk);
      rd(2'd2, d);
      k++;
    end while (d[31] && k < 60);
    expect_val({tag, " start clears"}, int'(d[31]), 0);
  endtask

  task automatic count_busy(input int which, output int n);
    logic b;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      b = (which == 0) ? softRstBusy : (which == 1) ? fifoRstBusy : dmaRstBusy;
      if (!b) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    int n;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); expect_val("R1 gctl", int'(d), 0);
    rd(2'd1, d); expect_val("R1 clk reg", int'(d), 0);
    rd(2'd2, d); expect_val("R1 cmd", int'(d), 0);
    expect_val("R1 busy pins", int'({softRstBusy, fifoRstBusy, dmaRstBusy, irqEnable, dmaEnable, ddrMode}), 0);
    measure(40, n); expect_val("R1 clock idle", n, 0);

    // R4 bypass
    wr(2'd1, 32'h0001_0000);
    update("R3 bypass");
    measure(WIN, n); expect_val("R4 bypass edges", n, WIN);

    // R4 divide by 3
    wr(2'd1, 32'h0001_0003);
    update("R3 div3");
    measure(WIN, n); expect_val("R4 div3 edges", n, WIN / 6);

    // R2 staged only
    wr(2'd1, 32'h0001_0006);
    rd(2'd1, d); expect_val("R2 readback", int'(d), 32'h0001_0006);
    measure(WIN, n); expect_val("R2 clock unchanged", n, WIN / 6);

    // R3 command without update-only is ignored
    wr(2'd2, 32'h8000_0011);
    rd(2'd2, d); expect_val("R3 plain cmd ignored", int'(d), 0);
    measure(WIN, n); expect_val("R3 clock unchanged", n, WIN / 6);

    // R7 live switch 3 -> 6, shortest phase
    begin
      int minRun, runLen;
      logic prev;
      bit seen;
      minRun = 1000; runLen = 0; seen = 0; prev = cardClk;
      fork
        begin
          for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            #1;
            if (cardClk != prev) begin
              if (seen && runLen < minRun) minRun = runLen;
              seen = 1; runLen = 1; prev = cardClk;
            end else runLen++;
          end
        end
        begin
          repeat (11) @(negedge clk);
          wr(2'd2, 32'h8020_2000);
        end
      join
      expect_val("R7 shortest phase >= 3", (minRun >= 3) ? 1 : 0, 1);
    end
    measure(WIN, n); expect_val("R4 div6 edges", n, WIN / 12);

    wr(2'd1, 32'h0001_0001); update("R3 div1");
    measure(WIN, n); expect_val("R4 div1 edges", n, WIN / 2);
    wr(2'd1, 32'h0001_0005); update("R3 div5");
    measure(WIN, n); expect_val("R4 div5 edges", n, WIN / 10);

    // R5 enable off
    wr(2'd1, 32'h0000_0005); update("R3 off");
    repeat (12) @(negedge clk);
    measure(WIN, n); expect_val("R5 divided off", n, 0);
    wr(2'd1, 32'h0000_0000); update("R3 off bypass");
    measure(WIN, n); expect_val("R5 bypass off", n, 0);

    // R6 low-power gating
    busIdle = 1'b1;
    wr(2'd1, 32'h0003_0002); update("R3 lp");
    repeat (10) @(negedge clk);
    measure(WIN, n); expect_val("R6 idle stops", n, 0);
    busIdle = 1'b0;
    repeat (10) @(negedge clk);
    measure(WIN, n); expect_val("R6 busy runs", n, WIN / 4);
    wr(2'd1, 32'h0003_0000); update("R3 lp bypass");
    measure(WIN, n); expect_val("R6 bypass runs", n, WIN);
    busIdle = 1'b1;
    @(negedge clk);
    measure(WIN, n); expect_val("R6 bypass idle stops", n, 0);
    busIdle = 1'b0;

    // R8 self-clearing reset bits
    wr(2'd0, 32'h1);
    rd(2'd0, d); expect_val("R8 soft bit set", int'(d[0]), 1);
    count_busy(0, n); expect_val("R8 soft length", n, SOFT_LEN);
    rd(2'd0, d); expect_val("R8 soft bit clear", int'(d[0]), 0);
    wr(2'd0, 32'h2); count_busy(1, n); expect_val("R8 fifo length", n, FIFO_LEN);
    wr(2'd0, 32'h4); count_busy(2, n); expect_val("R8 dma length", n, DMA_LEN);
    rd(2'd0, d); expect_val("R8 all clear", int'(d[2:0]), 0);

    // R9 mode bits and reset persistence
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h0000_0430);
    count_busy(0, n); expect_val("R9 reset not restarted", n, SOFT_LEN - 1);
    rd(2'd0, d); expect_val("R9 mode readback", int'(d), 32'h430);
    expect_val("R9 mode pins", int'({irqEnable, dmaEnable, ddrMode}), 3'b111);
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, d); expect_val("R9 mode readback 2", int'(d), 32'h10);
    expect_val("R9 mode pins 2", int'({irqEnable, dmaEnable, ddrMode}), 3'b100);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule